// File: doc/BRIEF.md
# Prescaled Compare Timer with Sticky Alarm

This block is a 32-bit general-purpose timer reached through a simple word-addressed register bus. The bus has a write strobe, a read strobe, a byte address, write data and registered read data. Three registers are mapped:

- **control** holds the enable, the prescaler code, the run mode and the alarm flag.
- **threshold** holds the compare value.
- **counter** holds the running count.

A prescaler divides the system clock by a power of two chosen by the prescaler code, and each prescaler tick lets the counter step once.

When a tick finds the counter equal to the threshold while the timer is enabled, a sticky alarm flag is set. The interrupt output follows the level of that flag. After a match, the counter does one of two things:

- **Continuous mode:** the counter returns to zero and keeps counting.
- **Single-shot mode:** the counter freezes on the matching value until software rewrites it or toggles the enable.

Software clears the alarm by writing zero to its control bit, or by disabling the timer.

The block has no data stream, so every pin is a plain control or status signal. There is no valid/ready handshake and no back-pressure.

Top module: `cmp_timer`

## Requirements
- R1: Register map by byte address: 0x0 is control, 0x4 is threshold, 0x8 is counter. Control bit 0 is enable, bits 3:1 are the prescaler code, bit 4 is mode (0 single-shot, 1 continuous) and bit 5 is the alarm flag. Control bits 31:6 read as zero. Threshold and counter read back their current values. Reset clears every register.
- R2: Prescaler codes 0 to 7 give a tick every 2, 4, 8, 64, 128, 1024, 2048 and 4096 clocks. With counter and threshold both zero, the alarm appears exactly that many clocks after the edge that writes the enable.
- R3: The alarm is set only on a prescaler tick while the timer is enabled and the counter equals the threshold.
- R4: Once set, the alarm stays set until a control write carries 0 in bit 5. A control write carrying 1 in bit 5 leaves the alarm unchanged.
- R5: A control write with enable at 0 clears the alarm and the interrupt in the same edge. While disabled, the alarm stays clear.
- R6: The interrupt output `irq` is the level of the alarm flag, and control bit 5 reads that same flag.
- R7: The prescaler is held at its start while the timer is disabled, so the tick phase restarts from each enable.
- R8: In continuous mode, a matching tick returns the counter to zero, and the next alarm follows threshold+1 ticks later.
- R9: In single-shot mode, a matching tick freezes the counter on the threshold value. It stays frozen, with no new alarm, until the counter is rewritten or the enable is cleared.
- R10: A counter write takes priority over an increment or wrap in the same clock.
- R11: Read data is captured on the edge where the read strobe is high and holds until the next read.
- R12: Writes to an unmapped address change no register, and reads from it return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one write per high cycle |
| bus_re | input | 1 | Read strobe, one read per high cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_re` |
| irq | output | 1 | Level interrupt, high while the alarm is pending |

## Verification
The in-RTL properties assume that `rst_n` is low across at least one rising edge before any strobe, and that the strobes, the address and the write data are never unknown once reset has been released. The stickiness property further assumes that control changes only through the write strobe. The bench meets these assumptions in three ways:
- It holds reset for several cycles with both strobes low.
- It changes inputs only at falling clock edges.
- It deasserts each strobe after exactly one rising edge.

Timing-sensitive checks, such as alarm latency, wrap period and same-cycle write priority, are scheduled by counting edges from the enable write. This works because the prescaler phase restarts at every enable.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;

  localparam int unsigned CT_EN_BIT    = 0;
  localparam int unsigned CT_SEL_LSB   = 1;
  localparam int unsigned CT_SEL_W     = 3;
  localparam int unsigned CT_MODE_BIT  = 4;
  localparam int unsigned CT_ALARM_BIT = 5;
  localparam int unsigned CT_USED_BITS = 6;

  localparam int unsigned OFS_CTRL  = 0;
  localparam int unsigned OFS_THRES = 4;
  localparam int unsigned OFS_COUNT = 8;

  localparam int unsigned PSC_MAX_LOG2 = 12;

  typedef enum logic [1:0] {
    RSEL_CTRL  = 2'd0,
    RSEL_THRES = 2'd1,
    RSEL_COUNT = 2'd2,
    RSEL_NONE  = 2'd3
  } reg_sel_e;

  // Power-of-two exponent of the clock divider for each prescaler code.
  function automatic int unsigned psc_log2(input logic [CT_SEL_W-1:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 2;
      3'd2:    return 3;
      3'd3:    return 6;
      3'd4:    return 7;
      3'd5:    return 10;
      3'd6:    return 11;
      default: return 12;
    endcase
  endfunction

endpackage

// File: rtl/cmp_timer_prescaler.sv
module cmp_timer_prescaler
  import cmp_timer_pkg::*;
#(
  parameter int unsigned PSC_W = PSC_MAX_LOG2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [CT_SEL_W-1:0] sel,
  output logic                tick
);

  logic [PSC_W-1:0] pcnt;
  logic [PSC_W-1:0] limit;

  // Terminal count is divider-1; ">=" keeps a code change mid-period safe.
  always_comb begin
    limit = PSC_W'((32'd1 << psc_log2(sel)) - 32'd1);
  end

  assign tick = run && (pcnt >= limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pcnt <= '0;
    end else if (!run || tick) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  AST_TICK_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick) else $error("tick on adjacent cycles"); // R2

  AST_IDLE_PRESCALER_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pcnt == '0) || run) else $error("prescaler ran while idle"); // R7

endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic                bus_re,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [DATA_W-1:0]   cnt_val,
  input  logic                alarm,
  output logic                en,
  output logic                mode,
  output logic [CT_SEL_W-1:0] sel,
  output logic [DATA_W-1:0]   thres,
  output logic                ctrl_wr,
  output logic                cnt_wr,
  output logic [DATA_W-1:0]   bus_rdata
);

  localparam int unsigned PAD_W = DATA_W - CT_USED_BITS;

  reg_sel_e                 rsel;
  logic     [DATA_W-1:0]    rd_mux;
  logic                     thres_wr;
  logic     [DATA_W-1:0]    ctrl_view;

  // Full-address decode: byte offsets off the word grid are unmapped.
  always_comb begin
    if (bus_addr == ADDR_W'(OFS_CTRL)) begin
      rsel = RSEL_CTRL;
    end else if (bus_addr == ADDR_W'(OFS_THRES)) begin
      rsel = RSEL_THRES;
    end else if (bus_addr == ADDR_W'(OFS_COUNT)) begin
      rsel = RSEL_COUNT;
    end else begin
      rsel = RSEL_NONE;
    end
  end

  assign ctrl_wr  = bus_we && (rsel == RSEL_CTRL);
  assign thres_wr = bus_we && (rsel == RSEL_THRES);
  assign cnt_wr   = bus_we && (rsel == RSEL_COUNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en    <= 1'b0;
      mode  <= 1'b0;
      sel   <= '0;
      thres <= '0;
    end else begin
      if (ctrl_wr) begin
        en   <= bus_wdata[CT_EN_BIT];
        mode <= bus_wdata[CT_MODE_BIT];
        sel  <= bus_wdata[CT_SEL_LSB +: CT_SEL_W];
      end
      if (thres_wr) begin
        thres <= bus_wdata;
      end
    end
  end

  assign ctrl_view = {{PAD_W{1'b0}}, alarm, mode, sel, en};

  always_comb begin
    case (rsel)
      RSEL_CTRL:  rd_mux = ctrl_view;
      RSEL_THRES: rd_mux = thres;
      RSEL_COUNT: rd_mux = cnt_val;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      bus_rdata <= rd_mux;
    end
  end

  AST_CTRL_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && rsel == RSEL_CTRL) |=> (bus_rdata[DATA_W-1:CT_USED_BITS] == '0))
    else $error("unused control bits nonzero"); // R1

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata)) else $error("read data moved without read"); // R11

  AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && rsel == RSEL_NONE) |=> $stable(thres) && $stable(en) && $stable(mode))
    else $error("unmapped write changed a register"); // R12

endmodule

// File: rtl/cmp_timer_core.sv
module cmp_timer_core
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              mode,
  input  logic [DATA_W-1:0] thres,
  input  logic              tick,
  input  logic              ctrl_wr,
  input  logic              cnt_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cnt,
  output logic              alarm
);

  logic halted;
  logic step;
  logic match;
  logic hit;
  logic dis_wr;
  logic clr_wr;

  assign match  = (cnt == thres);
  assign step   = tick && en && !halted;
  assign hit    = step && match;
  assign dis_wr = ctrl_wr && !wdata[CT_EN_BIT];
  assign clr_wr = ctrl_wr && !wdata[CT_ALARM_BIT];

  // Counter: software write wins over stepping.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_wr) begin
      cnt <= wdata;
    end else if (step) begin
      if (match) begin
        cnt <= mode ? '0 : cnt;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // Single-shot freeze, released by a counter write or by disabling.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halted <= 1'b0;
    end else if (cnt_wr || dis_wr || !en) begin
      halted <= 1'b0;
    end else if (hit && !mode) begin
      halted <= 1'b1;
    end
  end

  // Alarm: disable beats a new match, a new match beats a software clear.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm <= 1'b0;
    end else if (!en || dis_wr) begin
      alarm <= 1'b0;
    end else if (hit) begin
      alarm <= 1'b1;
    end else if (clr_wr) begin
      alarm <= 1'b0;
    end
  end

  AST_ALARM_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(tick && en && cnt == thres)) else $error("alarm without match"); // R3

  AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !ctrl_wr) |=> alarm) else $error("alarm dropped on its own"); // R4

  AST_OFF_NO_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !alarm) else $error("alarm while disabled"); // R5

  AST_CONT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && match && mode && !cnt_wr) |=> (cnt == '0)) else $error("no wrap"); // R8

  AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && !cnt_wr) |=> $stable(cnt)) else $error("frozen counter moved"); // R9

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata))) else $error("counter write lost"); // R10

endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned PSC_W  = PSC_MAX_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  logic                en;
  logic                mode;
  logic [CT_SEL_W-1:0] sel;
  logic [DATA_W-1:0]   thres;
  logic                ctrl_wr;
  logic                cnt_wr;
  logic [DATA_W-1:0]   cnt;
  logic                alarm;
  logic                tick;

  cmp_timer_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .cnt_val   (cnt),
    .alarm     (alarm),
    .en        (en),
    .mode      (mode),
    .sel       (sel),
    .thres     (thres),
    .ctrl_wr   (ctrl_wr),
    .cnt_wr    (cnt_wr),
    .bus_rdata (bus_rdata)
  );

  cmp_timer_prescaler #(
    .PSC_W (PSC_W)
  ) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (en),
    .sel   (sel),
    .tick  (tick)
  );

  cmp_timer_core #(
    .DATA_W (DATA_W)
  ) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .mode    (mode),
    .thres   (thres),
    .tick    (tick),
    .ctrl_wr (ctrl_wr),
    .cnt_wr  (cnt_wr),
    .wdata   (bus_wdata),
    .cnt     (cnt),
    .alarm   (alarm)
  );

  assign irq = alarm;

  AST_IRQ_FOLLOWS_ALARM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(OFS_CTRL)) |=> (bus_rdata[CT_ALARM_BIT] == $past(irq)))
    else $error("alarm bit and irq disagree"); // R6

endmodule

// File: tb/cmp_timer_bench.sv
module cmp_timer_bench;

  localparam int unsigned DW = 32;
  localparam int unsigned AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0;
  logic          bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_timer #(.DATA_W(DW), .ADDR_W(AW)) u_cmp_timer (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [AW-1:0] A_CTRL = 4'h0;
  localparam logic [AW-1:0] A_THR  = 4'h4;
  localparam logic [AW-1:0] A_CNT  = 4'h8;
  localparam logic [AW-1:0] A_NONE = 4'hC;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // All tasks are entered and left at a falling edge.
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wait_irq(input int lim, output int n);
    n = 0;
    while (!irq && n < lim) begin
      @(posedge clk); @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    logic [DW-1:0] d;
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    rd(A_CTRL, d); chk("R1 ctrl reset", d, 32'd0);
    rd(A_THR, d);  chk("R1 thres reset", d, 32'd0);
    rd(A_CNT, d);  chk("R1 count reset", d, 32'd0);
  endtask

  task automatic t_regmap();
    logic [DW-1:0] d;
    wr(A_CTRL, 32'hFFFF_FFDE);
    rd(A_CTRL, d); chk("R1 ctrl fields, pad zero", d, 32'h0000_001E);
    wr(A_THR, 32'hA5A5_1234);
    rd(A_THR, d);  chk("R1 thres readback", d, 32'hA5A5_1234);
    wr(A_CNT, 32'h0F0F_F0F0);
    rd(A_CNT, d);  chk("R1 count readback", d, 32'h0F0F_F0F0);
    wr(A_NONE, 32'hDEAD_BEEF);
    wr(4'h1, 32'h1234_5678);
    rd(A_CTRL, d); chk("R12 ctrl untouched", d, 32'h0000_001E);
    rd(A_THR, d);  chk("R12 thres untouched", d, 32'hA5A5_1234);
    rd(A_CNT, d);  chk("R12 count untouched", d, 32'h0F0F_F0F0);
    rd(A_NONE, d); chk("R12 unmapped reads zero", d, 32'd0);
    idle(3);
    chk("R11 rdata held without read", bus_rdata, 32'd0);
    wr(A_CTRL, 32'd0);
  endtask

  task automatic t_prescale();
    int n;
    for (int s = 0; s < 8; s++) begin
      int exp_div;
      case (s)
        0: exp_div = 2;    1: exp_div = 4;    2: exp_div = 8;    3: exp_div = 64;
        4: exp_div = 128;  5: exp_div = 1024; 6: exp_div = 2048; default: exp_div = 4096;
      endcase
      wr(A_CTRL, 32'd0);
      wr(A_CNT, 32'd0);
      wr(A_THR, 32'd0);
      idle(s + 1); // R7: disabled time must not shift the phase
      wr(A_CTRL, 32'(1 | (s << 1)));
      wait_irq(5000, n);
      chk($sformatf("R2 R7 alarm latency code %0d", s), 32'(n), 32'(exp_div));
    end
    wr(A_CTRL, 32'd0);
  endtask

  task automatic t_single();
    int n;
    logic [DW-1:0] d;
    wr(A_CTRL, 32'd0);
    wr(A_CNT, 32'd0);
    wr(A_THR, 32'd2);
    wr(A_CTRL, 32'h0000_0001);
    wait_irq(100, n);
    chk("R3 single-shot alarm after 3 ticks", 32'(n), 32'd6);
    rd(A_CNT, d);  chk("R9 count frozen on threshold", d, 32'd2);
    rd(A_CTRL, d); chk("R6 alarm bit reads set", d, 32'h0000_0021);
    idle(20);
    rd(A_CNT, d);  chk("R9 count still frozen", d, 32'd2);
    wr(A_CTRL, 32'h0000_0021);
    chk("R4 writing one keeps alarm", {31'd0, irq}, 32'd1);
    idle(5);
    chk("R4 alarm sticky", {31'd0, irq}, 32'd1);
    wr(A_CTRL, 32'h0000_0001);
    chk("R4 writing zero clears alarm", {31'd0, irq}, 32'd0);
    idle(20);
    chk("R9 no new alarm while frozen", {31'd0, irq}, 32'd0);
    wr(A_CNT, 32'd0);
    wait_irq(10, n);
    chk("R9 rewrite restarts counting", {31'd0, irq}, 32'd1);
    wr(A_CTRL, 32'd0);
    chk("R5 disable clears irq", {31'd0, irq}, 32'd0);
    rd(A_CTRL, d); chk("R5 alarm bit clear after disable", d, 32'd0);
  endtask

  task automatic t_continuous();
    int n;
    logic [DW-1:0] d;
    wr(A_CNT, 32'd0);
    wr(A_THR, 32'd2);
    wr(A_CTRL, 32'h0000_0011);
    wait_irq(100, n);
    chk("R3 continuous first alarm", 32'(n), 32'd6);
    wr(A_CTRL, 32'h0000_0011);
    chk("R4 clear in continuous mode", {31'd0, irq}, 32'd0);
    wait_irq(100, n);
    chk("R8 next alarm after threshold+1 ticks", 32'(n), 32'd5);
    rd(A_CNT, d); chk("R8 count wrapped to zero", d, 32'd0);
    wr(A_CTRL, 32'h0000_0010);
    chk("R5 disable clears continuous alarm", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_write_priority();
    logic [DW-1:0] d;
    wr(A_CTRL, 32'd0);
    wr(A_THR, 32'h0000_FFFF);
    wr(A_CNT, 32'd0);
    wr(A_CTRL, 32'h0000_0011);
    idle(1);
    wr(A_CNT, 32'd100); // lands on the first tick edge
    rd(A_CNT, d); chk("R10 counter write beats increment", d, 32'd100);
    wr(A_CTRL, 32'd0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_single();
    t_continuous();
    t_write_priority();
    t_prescale();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule